// File: doc/BRIEF.md
# Reset Cause Recorder with Software One-Shot Resets

This block records which reset sources have fired since the flags were last initialised, and lets software start a reset of its own. Seven reset sources feed it with single-cycle pulses: power-on, the external reset pin, the watchdog, low-voltage detection, brown-out detection, a processor reset request and a processor-only reset. Each source has a sticky flag in a status word. The flags survive the resets they record. Software reads them to find out why the chip restarted, then clears each one by writing 1 to its bit.

Software can also start two kinds of reset through a control word. One resets the whole chip and the other resets only the processor core and its flash controller. Each control bit drives its reset output for a fixed number of cycles and then clears itself. Starting one of these resets also sets the matching flag. Both control bits are write-protected and only accept a write while the unlock input from a separate unlock block is high. A third word holds a 16-bit key. When that word holds the magic value, the power-on reset circuit is told to stand down. Any reset event re-arms the power-on reset.

The register port takes single-cycle requests. Read data appears on the cycle after the request. Word 0 is the status, word 1 is the control, and word 2 is the key.

Top module: `rst_cause_ctrl`

## Requirements
- R1: A pulse on source input i sets status bit i for i = 0..5. A pulse on source input 6 (processor-only) sets status bit 7. Status bit 6 always reads 0. Pulses on several sources in the same cycle set all of their flags.
- R2: Writing to status word 0 clears exactly the flags whose data bits are 1. Data bits that are 0 leave their flags unchanged. No flag clears without such a write or the flag-initialise input.
- R3: When a flag is cleared and its source pulses in the same cycle, the flag ends up set.
- R4: Only `flag_init` clears the status flags. The block reset `rst` leaves them unchanged.
- R5: With `unlock_i` high, writing 1 to control bit 0 (word 1) raises `chip_rst_o` in the cycle after the write. The output stays high for PULSE_CYC cycles (2 by default), then falls. Status bit 0 is set at the same edge.
- R6: With `unlock_i` high, writing 1 to control bit 1 raises `core_rst_o` for PULSE_CYC cycles. Status bit 7 is set at the same edge.
- R7: Writes to the control word and the key word are ignored while `unlock_i` is low. The status word is not protected.
- R8: An unlocked write of 0x5AA5 to key word 2 drives `por_disable_o` high from the next cycle. An unlocked write of any other value drives it low.
- R9: Any source pulse, or the start of either one-shot reset, clears the key and drives `por_disable_o` low from the next cycle. This takes priority over a key write in the same cycle.
- R10: A read returns data on `rd_data` one cycle after the request. Word 1 reads back bit 0 = chip reset active and bit 1 = core reset active. Word 2 reads back the stored key. `rst` clears the key, both one-shot resets and `rd_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset for key, one-shot resets and read data |
| flag_init | input | 1 | Synchronous active-high power-good initialise of the status flags |
| src_i | input | 7 | Reset source pulses: power-on, pin, watchdog, low-voltage, brown-out, processor request, processor-only |
| unlock_i | input | 1 | Write-protect release for the control and key words |
| req_valid | input | 1 | Register request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data, valid the cycle after a read request |
| chip_rst_o | output | 1 | Whole-chip reset pulse |
| core_rst_o | output | 1 | Core-only reset pulse |
| por_disable_o | output | 1 | High while the key word holds the disable key |

## Verification
Some cases are hard to reach from the ports because they need two events to land on one clock edge. A source pulse can coincide with a write-1 clear of its own flag. A key write can coincide with a re-arming reset event. The stimulus table drives source pulses and status writes in the same cycle to bring the clear-versus-set race about. Directed steps arm the key and then fire a source pulse or a one-shot reset to show the re-arm. The width of the one-shot pulse is sampled on each falling edge after the unlocked write. The survival of the flags across `rst` is shown by setting a flag, pulsing `rst` and reading the status back.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  // Source input indices and the count of them.
  localparam int SRC_N    = 7;
  localparam int STAT_W   = 8;
  localparam int RSVD_BIT = 6;

  // One-shot request indices (also their control-word bit positions).
  localparam int OS_N    = 2;
  localparam int OS_CHIP = 0;
  localparam int OS_CORE = 1;

  // Word addresses of the register port.
  localparam int A_STATUS = 0;
  localparam int A_CTRL   = 1;
  localparam int A_KEY    = 2;

  // Status bit that a source input sets: bit 6 is skipped.
  function automatic int src_to_bit(input int idx);
    return (idx < RSVD_BIT) ? idx : idx + 1;
  endfunction

  // Status bit that a one-shot request sets.
  function automatic int os_to_bit(input int k);
    return (k == OS_CHIP) ? 0 : STAT_W - 1;
  endfunction
endpackage

// File: rtl/rcc_flags.sv
module rcc_flags
  import rcc_pkg::*;
(
  input  logic              clk,
  input  logic              flag_init,
  input  logic [SRC_N-1:0]  src_i,
  input  logic [OS_N-1:0]   os_start,
  input  logic [STAT_W-1:0] clr_i,
  output logic [STAT_W-1:0] flags_q
);
  localparam logic [STAT_W-1:0] RSVD_MASK = STAT_W'(1) << RSVD_BIT;

  logic [STAT_W-1:0] set_v;

  always_comb begin
    set_v = '0;
    for (int i = 0; i < SRC_N; i++) set_v[src_to_bit(i)] = set_v[src_to_bit(i)] | src_i[i];
    for (int k = 0; k < OS_N; k++)  set_v[os_to_bit(k)]  = set_v[os_to_bit(k)]  | os_start[k];
  end

  // A new event wins over a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (flag_init) flags_q <= '0;
    else           flags_q <= ((flags_q & ~clr_i) | set_v) & ~RSVD_MASK;
  end
endmodule

// File: rtl/rcc_oneshot.sv
module rcc_oneshot #(
  parameter int PULSE_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic active_o
);
  localparam int CNT_W = $clog2(PULSE_CYC + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_CYC);

  logic [CNT_W-1:0] cnt_q, cnt_nxt;

  always_comb begin
    if (start_i)         cnt_nxt = LOAD;
    else if (cnt_q != 0) cnt_nxt = cnt_q - 1'b1;
    else                 cnt_nxt = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      active_o <= 1'b0;
    end else begin
      cnt_q    <= cnt_nxt;
      active_o <= (cnt_nxt != 0);
    end
  end
endmodule

// File: rtl/rcc_porkey.sv
module rcc_porkey #(
  parameter int              KEY_W   = 16,
  parameter logic [KEY_W-1:0] KEY_VAL = 16'h5AA5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [KEY_W-1:0] wdata,
  input  logic             rearm,
  output logic [KEY_W-1:0] key_q,
  output logic             disable_o
);
  logic [KEY_W-1:0] key_nxt;

  always_comb begin
    if (rearm)      key_nxt = '0;
    else if (wr_en) key_nxt = wdata;
    else            key_nxt = key_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      key_q     <= '0;
      disable_o <= 1'b0;
    end else begin
      key_q     <= key_nxt;
      disable_o <= (key_nxt == KEY_VAL);
    end
  end
endmodule

// File: rtl/rcc_regif.sv
module rcc_regif
  import rcc_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              unlock_i,
  input  logic [STAT_W-1:0] flags_q,
  input  logic [OS_N-1:0]   os_active,
  input  logic [DATA_W-1:0] key_q,
  output logic [STAT_W-1:0] stat_clr,
  output logic [OS_N-1:0]   os_start,
  output logic              key_wr,
  output logic [DATA_W-1:0] rd_data
);
  logic hit_stat, hit_ctrl, hit_key, wr, rd;
  logic [DATA_W-1:0] rd_mux;

  assign hit_stat = (req_addr == ADDR_W'(A_STATUS));
  assign hit_ctrl = (req_addr == ADDR_W'(A_CTRL));
  assign hit_key  = (req_addr == ADDR_W'(A_KEY));
  assign wr       = req_valid &  req_write;
  assign rd       = req_valid & ~req_write;

  assign stat_clr = (wr && hit_stat) ? req_wdata[STAT_W-1:0] : '0;
  assign os_start = (wr && hit_ctrl && unlock_i) ? req_wdata[OS_N-1:0] : '0;
  assign key_wr   = wr && hit_key && unlock_i;

  always_comb begin
    rd_mux = '0;
    if (hit_stat)     rd_mux = DATA_W'(flags_q);
    else if (hit_ctrl) rd_mux = DATA_W'(os_active);
    else if (hit_key)  rd_mux = key_q;
  end

  always_ff @(posedge clk) begin
    if (rst)     rd_data <= '0;
    else if (rd) rd_data <= rd_mux;
  end
endmodule

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl
  import rcc_pkg::*;
#(
  parameter int              ADDR_W    = 2,
  parameter int              DATA_W    = 16,
  parameter int              PULSE_CYC = 2,
  parameter logic [DATA_W-1:0] KEY_VAL = 16'h5AA5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flag_init,
  input  logic [SRC_N-1:0]  src_i,
  input  logic              unlock_i,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              chip_rst_o,
  output logic              core_rst_o,
  output logic              por_disable_o
);
  logic [STAT_W-1:0] flags_q, stat_clr;
  logic [OS_N-1:0]   os_start, os_active;
  logic [DATA_W-1:0] key_q;
  logic              key_wr, rearm;

  rcc_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regif (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .unlock_i(unlock_i), .flags_q(flags_q),
    .os_active(os_active), .key_q(key_q),
    .stat_clr(stat_clr), .os_start(os_start),
    .key_wr(key_wr), .rd_data(rd_data)
  );

  rcc_flags u_flags (
    .clk(clk), .flag_init(flag_init), .src_i(src_i),
    .os_start(os_start), .clr_i(stat_clr), .flags_q(flags_q)
  );

  for (genvar k = 0; k < OS_N; k++) begin : g_os
    rcc_oneshot #(.PULSE_CYC(PULSE_CYC)) u_os (
      .clk(clk), .rst(rst), .start_i(os_start[k]), .active_o(os_active[k])
    );
  end

  assign rearm = (|src_i) | (|os_start);

  rcc_porkey #(.KEY_W(DATA_W), .KEY_VAL(KEY_VAL)) u_key (
    .clk(clk), .rst(rst), .wr_en(key_wr), .wdata(req_wdata),
    .rearm(rearm), .key_q(key_q), .disable_o(por_disable_o)
  );

  assign chip_rst_o = os_active[OS_CHIP];
  assign core_rst_o = os_active[OS_CORE];
endmodule

// File: rtl/rcc_chk.sv
module rcc_chk
  import rcc_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int PULSE_CYC = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              flag_init,
  input logic [SRC_N-1:0]  src_i,
  input logic              unlock_i,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              chip_rst_o,
  input logic              core_rst_o,
  input logic              por_disable_o,
  input logic [STAT_W-1:0] flags
);
  logic [7:0] chip_run;
  logic       stat_wr;

  assign stat_wr = req_valid && req_write && (req_addr == ADDR_W'(A_STATUS));

  always_ff @(posedge clk) begin
    if (rst || !chip_rst_o) chip_run <= '0;
    else if (chip_run != 8'hFF) chip_run <= chip_run + 1'b1;
  end

  AST_CHIP_LEN: assert property (@(posedge clk) disable iff (rst || flag_init)
    chip_rst_o |-> (chip_run < 8'(PULSE_CYC))); // R5
  AST_CHIP_FLAG: assert property (@(posedge clk) disable iff (rst || flag_init)
    $rose(chip_rst_o) |-> flags[0]); // R5
  AST_CORE_FLAG: assert property (@(posedge clk) disable iff (rst || flag_init)
    $rose(core_rst_o) |-> flags[STAT_W-1]); // R6
  AST_LOCKED: assert property (@(posedge clk) disable iff (rst || flag_init)
    (!chip_rst_o && !(req_valid && req_write && unlock_i)) |=> !chip_rst_o); // R7
  AST_KEY_REARM: assert property (@(posedge clk) disable iff (rst || flag_init)
    (|src_i) |=> !por_disable_o); // R9
  AST_W1C_HOLD: assert property (@(posedge clk) disable iff (rst || flag_init)
    !stat_wr |=> ((flags & $past(flags)) == $past(flags))); // R2
  AST_SRC_SET: assert property (@(posedge clk) disable iff (rst || flag_init)
    src_i[SRC_N-1] |=> flags[STAT_W-1]); // R1
endmodule

bind rst_cause_ctrl rcc_chk #(.ADDR_W(ADDR_W), .PULSE_CYC(PULSE_CYC)) u_chk (
  .clk(clk), .rst(rst), .flag_init(flag_init), .src_i(src_i),
  .unlock_i(unlock_i), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .chip_rst_o(chip_rst_o), .core_rst_o(core_rst_o),
  .por_disable_o(por_disable_o), .flags(flags_q)
);

// File: tb/sim_rst_cause_ctrl.sv
module sim_rst_cause_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst, flag_init, unlock, req_valid, req_write;
  logic [6:0]  src;
  logic [1:0]  req_addr;
  logic [15:0] req_wdata, rd_data;
  logic        chip_rst_o, core_rst_o, por_disable_o;
  int          n_chk = 0;
  int          n_bad = 0;
  logic [15:0] v;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_cause_ctrl u0 (
    .clk(clk), .rst(rst), .flag_init(flag_init), .src_i(src),
    .unlock_i(unlock), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
    .chip_rst_o(chip_rst_o), .core_rst_o(core_rst_o), .por_disable_o(por_disable_o)
  );

  typedef struct packed {
    logic [6:0]  s;
    logic        w;
    logic [15:0] d;
    logic [7:0]  e;
  } vec_t;

  // Source pulse and status write driven in one cycle; expected status after.
  localparam vec_t VT [12] = '{
    '{7'h01, 1'b0, 16'h0000, 8'h01},
    '{7'h06, 1'b0, 16'h0000, 8'h07},
    '{7'h00, 1'b1, 16'h0002, 8'h05},
    '{7'h00, 1'b1, 16'h0000, 8'h05},
    '{7'h40, 1'b0, 16'h0000, 8'h85},
    '{7'h18, 1'b0, 16'h0000, 8'h9D},
    '{7'h20, 1'b0, 16'h0000, 8'hBD},
    '{7'h00, 1'b1, 16'h00FF, 8'h00},
    '{7'h7F, 1'b0, 16'h0000, 8'hBF},
    '{7'h00, 1'b1, 16'h0040, 8'hBF},
    '{7'h04, 1'b1, 16'h0004, 8'hBF},
    '{7'h00, 1'b1, 16'h00BF, 8'h00}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic op(input logic [6:0] s, input logic w, input logic [1:0] a,
                    input logic [15:0] d, input logic u);
    @(negedge clk);
    src = s; req_valid = w; req_write = w; req_addr = a; req_wdata = d; unlock = u;
    @(negedge clk);
    src = '0; req_valid = 1'b0; req_write = 1'b0; unlock = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] val);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    val = rd_data;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1; flag_init = 1'b1; unlock = 1'b0; src = '0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0; flag_init = 1'b0;

    // Reset state
    check("R10 chip_rst idle", 16'(chip_rst_o), 16'h0);
    check("R10 core_rst idle", 16'(core_rst_o), 16'h0);
    check("R10 por_disable idle", 16'(por_disable_o), 16'h0);
    rd(2'd0, v); check("R4 status after init", v, 16'h0000);
    rd(2'd1, v); check("R10 ctrl after reset", v, 16'h0000);
    rd(2'd2, v); check("R10 key after reset", v, 16'h0000);

    // Vector table: R1 source mapping, R2 write-1-clear, R3 set beats clear
    for (int i = 0; i < 12; i++) begin
      op(VT[i].s, VT[i].w, 2'd0, VT[i].d, 1'b0);
      rd(2'd0, v);
      check($sformatf("R1 R2 R3 vector %0d", i), v, 16'(VT[i].e));
    end

    // R4: rst leaves flags alone
    op(7'h08, 1'b0, 2'd0, 16'h0, 1'b0);
    @(negedge clk); rst = 1'b1; @(negedge clk); @(negedge clk); rst = 1'b0;
    rd(2'd0, v); check("R4 flags survive rst", v, 16'h0008);
    op(7'h00, 1'b1, 2'd0, 16'h0008, 1'b0);

    // R7: locked chip reset write ignored
    op(7'h00, 1'b1, 2'd1, 16'h0001, 1'b0);
    check("R7 locked chip reset", 16'(chip_rst_o), 16'h0);
    @(negedge clk);
    check("R7 locked chip reset later", 16'(chip_rst_o), 16'h0);
    rd(2'd0, v); check("R7 locked no flag", v, 16'h0000);

    // R5: unlocked chip reset pulse width and flag
    op(7'h00, 1'b1, 2'd1, 16'h0001, 1'b1);
    check("R5 chip pulse cycle 1", 16'(chip_rst_o), 16'h1);
    @(negedge clk);
    check("R5 chip pulse cycle 2", 16'(chip_rst_o), 16'h1);
    @(negedge clk);
    check("R5 chip pulse ends", 16'(chip_rst_o), 16'h0);
    rd(2'd0, v); check("R5 chip flag", v, 16'h0001);
    op(7'h00, 1'b1, 2'd0, 16'h0001, 1'b0);

    // R6 and R10: core reset, control readback
    op(7'h00, 1'b1, 2'd1, 16'h0002, 1'b1);
    check("R6 core pulse", 16'(core_rst_o), 16'h1);
    check("R6 chip stays low", 16'(chip_rst_o), 16'h0);
    rd(2'd1, v); check("R10 ctrl shows core active", v, 16'h0002);
    check("R6 core pulse ends", 16'(core_rst_o), 16'h0);
    rd(2'd0, v); check("R6 core flag", v, 16'h0080);
    op(7'h00, 1'b1, 2'd0, 16'h0080, 1'b0);

    // R7/R8: key word protection and value
    op(7'h00, 1'b1, 2'd2, 16'h5AA5, 1'b0);
    check("R7 locked key write", 16'(por_disable_o), 16'h0);
    op(7'h00, 1'b1, 2'd2, 16'h5AA5, 1'b1);
    check("R8 key disables por", 16'(por_disable_o), 16'h1);
    rd(2'd2, v); check("R10 key readback", v, 16'h5AA5);
    op(7'h00, 1'b1, 2'd2, 16'h1234, 1'b1);
    check("R8 other value re-enables", 16'(por_disable_o), 16'h0);

    // R9: source pulse and one-shot re-arm
    op(7'h00, 1'b1, 2'd2, 16'h5AA5, 1'b1);
    op(7'h02, 1'b0, 2'd0, 16'h0, 1'b0);
    check("R9 source re-arms por", 16'(por_disable_o), 16'h0);
    op(7'h00, 1'b1, 2'd2, 16'h5AA5, 1'b1);
    check("R8 key set again", 16'(por_disable_o), 16'h1);
    op(7'h00, 1'b1, 2'd1, 16'h0001, 1'b1);
    check("R9 chip reset re-arms por", 16'(por_disable_o), 16'h0);
    rd(2'd2, v); check("R9 key cleared", v, 16'h0000);

    // R10: rst clears key
    op(7'h00, 1'b1, 2'd2, 16'h5AA5, 1'b1);
    @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
    check("R10 rst clears key", 16'(por_disable_o), 16'h0);
    rd(2'd0, v); check("R1 R4 status after sequence", v, 16'h0003);

    summary();
    $finish;
  end
endmodule